// File: doc/BRIEF.md
# Streaming RGB-to-Grayscale Pixel Converter

This block sits in line on a packed video word stream and turns each colour pixel into a single gray intensity. On every clock it takes one word with three unsigned colour channels and three control bits: line sync, frame sync and pixel-valid. It forms an integer weighted sum of the channels. It then divides that sum by the weight total, so the gray value is the truncated quotient and no real-number arithmetic is involved.

The gray value leaves two cycles later, repacked with the delayed control bits so that downstream logic sees one aligned word. A valid strobe comes with it, and so does a binary decision against a threshold that is supplied with each pixel.

Two-flop edge detectors watch the frame-sync and pixel-valid bits. They give a one-cycle frame-start pulse on the falling edge of frame sync and a run-start pulse on the rising edge of pixel-valid. Both pulses are aligned with the outputs. The divider is built either as a multiply by a fixed reciprocal followed by a shift, or as a plain constant divide; a parameter selects which.

Top module: `gray_pixel_pipe`

## Requirements
- R1: With the default 10-bit channels, the 33-bit input word is laid out as follows: red in bits [32:23], green in bits [22:13], blue in bits [12:3], line sync in bit 2, frame sync in bit 1 and pixel-valid in bit 0.
- R2: The gray value equals floor((30*red + 59*green + 11*blue) / 100). It always lies between the smallest and the largest of the three channels, so it fits in 10 bits.
- R3: The output word carries the gray value of the input word presented two clocks earlier in bits [12:3]. It carries that word's line sync, frame sync and pixel-valid bits in bits 2, 1 and 0. The gray field is filled for every word, and it is meaningful when the valid strobe is high.
- R4: The gray valid strobe is high exactly when the pixel-valid bit of the input two clocks earlier was 1.
- R5: The binary output is 1 only when the valid strobe is high and the gray value is greater than or equal to the threshold input presented with the same pixel. Otherwise it is 0.
- R6: A single-cycle frame-start pulse appears two clocks after frame sync is sampled 1 and then 0 on consecutive clocks.
- R7: A single-cycle run-start pulse appears two clocks after pixel-valid is sampled 0 and then 1 on consecutive clocks. The first sample after reset counts as following a 0.
- R8: Synchronous active-high reset clears all pipeline and sync history, so every output reads 0 during reset and on the first clock after it. A frame-sync level of 1 held through reset yields no frame-start pulse when the first post-reset sample is 0.
- R9: The reciprocal-multiply divider (DIV_MODE 0) and the exact constant divider (DIV_MODE 1) produce identical gray values over the full input range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_i | input | 3*CH_W+3 | Packed colour word: red, green, blue, line sync, frame sync, pixel-valid |
| thresh_i | input | CH_W | Threshold for the binary decision, taken with the same pixel |
| gray_word_o | output | CH_W+3 | Gray value with the delayed line sync, frame sync and pixel-valid bits |
| gray_valid_o | output | 1 | Gray value strobe |
| bin_o | output | 1 | Threshold decision, valid with the strobe |
| frame_start_o | output | 1 | One-cycle pulse on the frame-sync falling edge |
| run_start_o | output | 1 | One-cycle pulse on the pixel-valid rising edge |

## Verification
The bench builds two instances side by side, both with the default 10-bit channels and 30/59/11 weights. One uses the reciprocal divider with a 24-bit shift and the other uses the exact constant divide. Their gray outputs are compared against the same floor model. Full-scale channels, single-channel pixels and sums that truncate just below a multiple of 100 are mixed with seeded random words. This reaches the region where a reciprocal rounding error would first appear. Thresholds are drawn equal to and one above the expected gray, and bursts of frame-sync and pixel-valid toggling exercise coincident and back-to-back edges.

// File: rtl/gpp_pkg.sv
package gpp_pkg;

   // control bits carried beside the colour channels, lowest bits of the word
   typedef struct packed {
      logic hs;
      logic vs;
      logic pe;
   } gpp_ctl_t;

   localparam int GPP_CTL_W = 3;

   // divider variants
   localparam int GPP_DIV_RECIP = 0;
   localparam int GPP_DIV_EXACT = 1;

endpackage

// File: rtl/gpp_edge2.sv
module gpp_edge2 #(
   parameter bit RISE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic sig_i,
   output logic edge_o
);

   logic newer_q;
   logic older_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         newer_q <= 1'b0;
         older_q <= 1'b0;
      end else begin
         newer_q <= sig_i;
         older_q <= newer_q;
      end
   end

   generate
      if (RISE) begin : g_rise
         assign edge_o = newer_q & ~older_q;
      end else begin : g_fall
         assign edge_o = ~newer_q & older_q;
      end
   endgenerate

endmodule

// File: rtl/gpp_wsum.sv
module gpp_wsum #(
   parameter int CH_W  = 10,
   parameter int W_R   = 30,
   parameter int W_G   = 59,
   parameter int W_B   = 11,
   parameter int SUM_W = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CH_W-1:0]  red_i,
   input  logic [CH_W-1:0]  grn_i,
   input  logic [CH_W-1:0]  blu_i,
   output logic [SUM_W-1:0] sum_o
);

   localparam int MAX_SUM = ((1 << CH_W) - 1) * (W_R + W_G + W_B);

   if (MAX_SUM >= (1 << SUM_W)) begin : g_err_sum_w
      $error("gpp_wsum: SUM_W too narrow for weighted sum");
   end

   logic [SUM_W-1:0] sum_d;

   always_comb begin
      sum_d = SUM_W'(red_i) * SUM_W'(W_R)
            + SUM_W'(grn_i) * SUM_W'(W_G)
            + SUM_W'(blu_i) * SUM_W'(W_B);
   end

   always_ff @(posedge clk) begin
      if (rst) sum_o <= '0;
      else     sum_o <= sum_d;
   end

endmodule

// File: rtl/gpp_div.sv
module gpp_div #(
   parameter int CH_W     = 10,
   parameter int SUM_W    = 17,
   parameter int SCALE    = 100,
   parameter int DIV_MODE = 0,
   parameter int SHIFT    = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SUM_W-1:0] sum_i,
   output logic [CH_W-1:0]  quo_o
);

   import gpp_pkg::*;

   localparam longint unsigned TWO_S   = 64'd1 << SHIFT;
   localparam longint unsigned RECIP   = (TWO_S + longint'(SCALE) - 1) / longint'(SCALE);
   localparam longint unsigned ERR     = RECIP * longint'(SCALE) - TWO_S;
   localparam longint unsigned MAX_IN  = longint'(((1 << CH_W) - 1)) * longint'(SCALE);
   localparam int              RECIP_W = $clog2(RECIP + 1);
   localparam int              PROD_W  = SUM_W + RECIP_W;

   if (DIV_MODE != GPP_DIV_RECIP && DIV_MODE != GPP_DIV_EXACT) begin : g_err_mode
      $error("gpp_div: DIV_MODE must be 0 or 1");
   end

   if (SCALE < 2) begin : g_err_scale
      $error("gpp_div: SCALE must be at least 2");
   end

   logic [CH_W-1:0] quo_d;

   generate
      if (DIV_MODE == GPP_DIV_RECIP) begin : g_recip
         // exact floor requires the reciprocal error to stay below one step
         if (SHIFT > 40 || MAX_IN * ERR >= TWO_S) begin : g_err_shift
            $error("gpp_div: SHIFT too small for an exact reciprocal");
         end
         logic [PROD_W-1:0] prod;
         always_comb begin
            prod  = PROD_W'(sum_i) * PROD_W'(RECIP);
            quo_d = CH_W'(prod >> SHIFT);
         end
      end else begin : g_exact
         always_comb begin
            quo_d = CH_W'(sum_i / SUM_W'(SCALE));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) quo_o <= '0;
      else     quo_o <= quo_d;
   end

endmodule

// File: rtl/gray_pixel_pipe.sv
module gray_pixel_pipe #(
   parameter int CH_W     = 10,
   parameter int W_R      = 30,
   parameter int W_G      = 59,
   parameter int W_B      = 11,
   parameter int SCALE    = 100,
   parameter int DIV_MODE = 0,
   parameter int SHIFT    = 24
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [3*CH_W+2:0]     vid_i,
   input  logic [CH_W-1:0]       thresh_i,
   output logic [CH_W+2:0]       gray_word_o,
   output logic                  gray_valid_o,
   output logic                  bin_o,
   output logic                  frame_start_o,
   output logic                  run_start_o
);

   import gpp_pkg::*;

   localparam int WORD_W  = 3 * CH_W + GPP_CTL_W;
   localparam int RED_LSB = WORD_W - CH_W;
   localparam int GRN_LSB = WORD_W - 2 * CH_W;
   localparam int BLU_LSB = GPP_CTL_W;
   localparam int SUM_W   = $clog2(((1 << CH_W) - 1) * SCALE + 1);

   if (CH_W < 2 || CH_W > 16) begin : g_err_ch_w
      $error("gray_pixel_pipe: CH_W out of supported range");
   end

   if (W_R + W_G + W_B != SCALE) begin : g_err_weights
      $error("gray_pixel_pipe: weights must sum to SCALE");
   end

   // field split
   logic [CH_W-1:0] red;
   logic [CH_W-1:0] grn;
   logic [CH_W-1:0] blu;
   gpp_ctl_t        ctl_in;

   assign red    = vid_i[RED_LSB +: CH_W];
   assign grn    = vid_i[GRN_LSB +: CH_W];
   assign blu    = vid_i[BLU_LSB +: CH_W];
   assign ctl_in = gpp_ctl_t'(vid_i[GPP_CTL_W-1:0]);

   // arithmetic: stage 1 sum, stage 2 divide
   logic [SUM_W-1:0] sum_q1;
   logic [CH_W-1:0]  gray_q2;

   gpp_wsum #(
      .CH_W (CH_W),
      .W_R  (W_R),
      .W_G  (W_G),
      .W_B  (W_B),
      .SUM_W(SUM_W)
   ) u_wsum (
      .clk  (clk),
      .rst  (rst),
      .red_i(red),
      .grn_i(grn),
      .blu_i(blu),
      .sum_o(sum_q1)
   );

   gpp_div #(
      .CH_W    (CH_W),
      .SUM_W   (SUM_W),
      .SCALE   (SCALE),
      .DIV_MODE(DIV_MODE),
      .SHIFT   (SHIFT)
   ) u_div (
      .clk  (clk),
      .rst  (rst),
      .sum_i(sum_q1),
      .quo_o(gray_q2)
   );

   // control and threshold delay line, matched to the arithmetic
   gpp_ctl_t        ctl_q1, ctl_q2;
   logic [CH_W-1:0] thr_q1, thr_q2;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q1 <= '0;
         ctl_q2 <= '0;
         thr_q1 <= '0;
         thr_q2 <= '0;
      end else begin
         ctl_q1 <= ctl_in;
         ctl_q2 <= ctl_q1;
         thr_q1 <= thresh_i;
         thr_q2 <= thr_q1;
      end
   end

   // edge detection: two sampling flops plus one alignment flop
   logic vs_fall;
   logic pe_rise;
   logic frame_q2;
   logic run_q2;

   gpp_edge2 #(.RISE(1'b0)) u_vs_edge (
      .clk   (clk),
      .rst   (rst),
      .sig_i (ctl_in.vs),
      .edge_o(vs_fall)
   );

   gpp_edge2 #(.RISE(1'b1)) u_pe_edge (
      .clk   (clk),
      .rst   (rst),
      .sig_i (ctl_in.pe),
      .edge_o(pe_rise)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_q2 <= 1'b0;
         run_q2   <= 1'b0;
      end else begin
         frame_q2 <= vs_fall;
         run_q2   <= pe_rise;
      end
   end

   // outputs
   assign gray_word_o   = {gray_q2, ctl_q2};
   assign gray_valid_o  = ctl_q2.pe;
   assign bin_o         = ctl_q2.pe & (gray_q2 >= thr_q2);
   assign frame_start_o = frame_q2;
   assign run_start_o   = run_q2;

endmodule

// File: rtl/gpp_checker.sv
module gpp_checker #(
   parameter int CH_W = 10
) (
   input logic              clk,
   input logic              rst,
   input logic [3*CH_W+2:0] vid_i,
   input logic [CH_W-1:0]   thresh_i,
   input logic [CH_W+2:0]   gray_word_o,
   input logic              gray_valid_o,
   input logic              bin_o,
   input logic              frame_start_o,
   input logic              run_start_o
);

   localparam int WORD_W = 3 * CH_W + 3;

   logic [1:0]      cyc;
   logic [CH_W-1:0] c_r, c_g, c_b, c_min, c_max, gray;

   always_ff @(posedge clk) begin
      if (rst)            cyc <= 2'd0;
      else if (cyc != 3)  cyc <= cyc + 2'd1;
   end

   always_comb begin
      c_r   = vid_i[WORD_W-1 -: CH_W];
      c_g   = vid_i[WORD_W-1-CH_W -: CH_W];
      c_b   = vid_i[3 +: CH_W];
      c_min = (c_r < c_g) ? c_r : c_g;
      if (c_b < c_min) c_min = c_b;
      c_max = (c_r > c_g) ? c_r : c_g;
      if (c_b > c_max) c_max = c_b;
      gray  = gray_word_o[CH_W+2:3];
   end

   // R2: gray lies between channel minimum and maximum of its pixel
   a_r2_gray_bounded: assert property (@(posedge clk) disable iff (rst)
      (cyc == 2'd3 && gray_valid_o) |->
         (gray >= $past(c_min, 2) && gray <= $past(c_max, 2)));

   // R3: control bits come out two cycles after they went in
   a_r3_ctl_aligned: assert property (@(posedge clk) disable iff (rst)
      (cyc == 2'd3) |-> gray_word_o[2:0] == $past(vid_i[2:0], 2));

   // R4: valid strobe follows pixel-valid input
   a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
      (cyc == 2'd3) |-> gray_valid_o == $past(vid_i[0], 2));

   // R5: decision only with the strobe
   a_r5_bin_needs_valid: assert property (@(posedge clk) disable iff (rst)
      bin_o |-> gray_valid_o);

   // R5: decision against the threshold of the same pixel
   a_r5_bin_compare: assert property (@(posedge clk) disable iff (rst)
      (cyc == 2'd3 && gray_valid_o) |-> bin_o == (gray >= $past(thresh_i, 2)));

   // R6: frame start caused by a 1 then 0 on frame sync
   a_r6_frame_cause: assert property (@(posedge clk) disable iff (rst)
      (cyc == 2'd3 && frame_start_o) |->
         (!$past(vid_i[1], 2) && $past(vid_i[1], 3)));

   // R6: frame start lasts one cycle
   a_r6_frame_single: assert property (@(posedge clk) disable iff (rst)
      frame_start_o |=> !frame_start_o);

   // R7: run start caused by a 0 then 1 on pixel-valid
   a_r7_run_cause: assert property (@(posedge clk) disable iff (rst)
      (cyc == 2'd3 && run_start_o) |->
         ($past(vid_i[0], 2) && !$past(vid_i[0], 3)));

   // R8: no frame start before the history has refilled after reset
   a_r8_no_early_frame: assert property (@(posedge clk) disable iff (rst)
      (cyc != 2'd3) |-> !frame_start_o);

endmodule

bind gray_pixel_pipe gpp_checker #(.CH_W(CH_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .vid_i        (vid_i),
   .thresh_i     (thresh_i),
   .gray_word_o  (gray_word_o),
   .gray_valid_o (gray_valid_o),
   .bin_o        (bin_o),
   .frame_start_o(frame_start_o),
   .run_start_o  (run_start_o)
);

// File: tb/gray_pixel_pipe_tb.sv
`timescale 1ns/1ps
module gray_pixel_pipe_tb;

   localparam int N = 4000;

   logic        clk = 1'b0;
   logic        rst;
   logic [32:0] vid;
   logic [9:0]  thr;

   logic [12:0] word_a, word_b;
   logic        val_a, val_b, bin_a, bin_b, frm_a, frm_b, run_a, run_b;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [32:0] sv [N];
   logic [9:0]  st [N];

   always #2.5 clk = ~clk;

   gray_pixel_pipe #(.DIV_MODE(0)) u_dut (
      .clk(clk), .rst(rst), .vid_i(vid), .thresh_i(thr),
      .gray_word_o(word_a), .gray_valid_o(val_a), .bin_o(bin_a),
      .frame_start_o(frm_a), .run_start_o(run_a));

   gray_pixel_pipe #(.DIV_MODE(1)) u_dut_div (
      .clk(clk), .rst(rst), .vid_i(vid), .thresh_i(thr),
      .gray_word_o(word_b), .gray_valid_o(val_b), .bin_o(bin_b),
      .frame_start_o(frm_b), .run_start_o(run_b));

   function automatic logic [32:0] pack(input int r, input int g, input int b,
                                        input bit hs, input bit vs, input bit pe);
      return {10'(r), 10'(g), 10'(b), hs, vs, pe};
   endfunction

   // R1 layout, R2 formula
   function automatic int gray_ref(input logic [32:0] w);
      int r, g, b;
      r = int'(w[32:23]);
      g = int'(w[22:13]);
      b = int'(w[12:3]);
      return (30 * r + 59 * g + 11 * b) / 100;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic check_zero(input string tag);
      chk({tag, " R8 word"},  int'(word_a), 0);
      chk({tag, " R8 valid"}, int'(val_a), 0);
      chk({tag, " R8 bin"},   int'(bin_a), 0);
      chk({tag, " R8 frame"}, int'(frm_a), 0);
      chk({tag, " R8 run"},   int'(run_a), 0);
      chk({tag, " R8 word div"}, int'(word_b), 0);
   endtask

   task automatic check_step(input int j);
      int  g_exp;
      bit  pe, frame_exp, run_exp, bin_exp;
      g_exp     = gray_ref(sv[j]);
      pe        = sv[j][0];
      frame_exp = (j >= 1) && sv[j-1][1] && !sv[j][1];
      run_exp   = pe && ((j == 0) || !sv[j-1][0]);
      bin_exp   = pe && (g_exp >= int'(st[j]));
      chk($sformatf("R2 gray step %0d", j),     int'(word_a[12:3]), g_exp);
      chk($sformatf("R3 ctl step %0d", j),      int'(word_a[2:0]), int'(sv[j][2:0]));
      chk($sformatf("R4 valid step %0d", j),    int'(val_a), int'(pe));
      chk($sformatf("R5 bin step %0d", j),      int'(bin_a), int'(bin_exp));
      chk($sformatf("R6 frame step %0d", j),    int'(frm_a), int'(frame_exp));
      chk($sformatf("R7 run step %0d", j),      int'(run_a), int'(run_exp));
      chk($sformatf("R9 exact gray step %0d", j), int'(word_b[12:3]), g_exp);
      chk($sformatf("R9 exact ctl step %0d", j),
          int'({word_b[2:0], val_b, bin_b, frm_b, run_b}),
          int'({sv[j][2:0], pe, bin_exp, frame_exp, run_exp}));
   endtask

   // stimulus table: directed corners, then seeded random
   initial begin
      bit vs_s, pe_s;
      int r, g, b, m, ge;
      void'($urandom(32'd5150));
      sv[0] = pack(0, 0, 0, 0, 0, 1);          st[0] = 10'd0;    // R8: vs 1 in reset, 0 after
      sv[1] = pack(1023, 1023, 1023, 0, 0, 1); st[1] = 10'd1023; // full scale
      sv[2] = pack(1023, 0, 0, 0, 0, 1);       st[2] = 10'd307;  // 306 < 307
      sv[3] = pack(0, 1023, 0, 0, 0, 1);       st[3] = 10'd603;  // equal
      sv[4] = pack(0, 0, 1023, 0, 0, 0);       st[4] = 10'd0;    // not valid
      sv[5] = pack(100, 200, 300, 0, 1, 1);    st[5] = 10'd181;  // run start
      sv[6] = pack(1, 1, 1, 0, 0, 1);          st[6] = 10'd2;    // frame start
      sv[7] = pack(3, 0, 0, 0, 0, 1);          st[7] = 10'd1;    // truncation to 0
      sv[8] = pack(1022, 1023, 1021, 1, 1, 0); st[8] = 10'd0;
      sv[9] = pack(33, 1, 0, 0, 0, 1);         st[9] = 10'd10;   // frame and run together
      vs_s = 1'b0;
      pe_s = 1'b1;
      for (int i = 10; i < N; i++) begin
         m = int'($urandom_range(0, 7));
         r = (m == 0) ? 1023 : (m == 1) ? 0 : int'($urandom_range(0, 1023));
         g = (m == 2) ? 1023 : int'($urandom_range(0, 1023));
         b = (m == 3) ? 1023 : int'($urandom_range(0, 1023));
         if ($urandom_range(0, 29) == 0) vs_s = ~vs_s;
         if ($urandom_range(0, 5) == 0)  pe_s = ~pe_s;
         sv[i] = pack(r, g, b, 1'($urandom_range(0, 1)), vs_s, pe_s);
         ge = gray_ref(sv[i]);
         m  = int'($urandom_range(0, 3));
         if (m == 0)      st[i] = 10'(ge);
         else if (m == 1) st[i] = (ge == 1023) ? 10'd1023 : 10'(ge + 1);
         else             st[i] = 10'($urandom_range(0, 1023));
      end
   end

   initial begin
      rst = 1'b1;
      vid = pack(1023, 1023, 1023, 1, 1, 1);
      thr = 10'd0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check_zero("in reset");
      rst = 1'b0;
      for (int i = 0; i < N; i++) begin
         vid = sv[i];
         thr = st[i];
         @(posedge clk);
         @(negedge clk);
         if (i == 0) check_zero("first cycle");
         else        check_step(i - 1);
      end
      @(posedge clk);
      @(negedge clk);
      check_step(N - 1);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule